// File: doc/BRIEF.md
# Statistical Plaintext Scorer

The scorer judges whether a 64-bit trial plaintext word looks like the kind of data being hunted for. It splits the word into eight bytes and looks up a trainable 8-bit weight for each byte value. It then adds the eight weights and raises a match when the total is above a threshold. A search unit places it behind its decryptor so that likely keys can be flagged even when the exact plaintext is not known.

The weight table is shared by all eight byte lanes. It is held as four identical two-read-port copies, so that all eight lookups happen in the same cycle. A single write port fills every copy at once, which lets software train the table for English text, executable code or any other data type. The threshold does not have its own input. It arrives in the low 11 bits of the reference word input, which is the register a search unit already uses for known plaintext. A coarse mode compares only the top four bits of the sum and threshold, which shortens the final comparison.

The block takes one word on every clock. The lookup takes one stage, the adder tree takes three and the comparison takes one. A valid flag travels with each word, so every result appears a fixed five edges after its word.

Top module: `plaintext_scorer`

## Requirements
- R1: In full mode (`coarse_en`=0), `out_match` is 1 exactly when the 11-bit score sum is greater than the threshold `ref_word[10:0]`. Bits `ref_word[63:11]` have no effect on the result.
- R2: The score sum is the sum of `table[in_word[8k+7:8k]]` for k = 0..7. All lanes use one shared 256-entry table of 8-bit weights, and the sum reaches 2040 without wrapping.
- R3: A sum equal to the threshold is not a match.
- R4: In coarse mode (`coarse_en`=1), `out_match` is 1 exactly when sum[10:7] > threshold[10:7]. The low seven bits of both values are ignored.
- R5: A word sampled with `in_valid`=1 at one rising edge produces `out_valid`=1 after the fifth rising edge, counting the sampling edge as the first. `out_valid` is 0 in every other case.
- R6: A new word can be taken on every clock, and each result depends only on its own word. Its threshold and mode are those sampled on the same edge as the word.
- R7: `out_match` is never 1 while `out_valid` is 0.
- R8: When `tbl_we`=1 at an edge, the value `tbl_data` is written to entry `tbl_addr` of every copy of the table. A word sampled on that same edge still sees the old weight, and words sampled later see the new one.
- R9: While `rst_n` is low, and until a new word has passed through the pipeline, both outputs are 0. The table contents are kept through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word on `in_word` is to be scored |
| in_word | input | 64 | Trial plaintext word |
| ref_word | input | 64 | Reference register; bits 10:0 carry the threshold |
| coarse_en | input | 1 | 1 selects the four-bit coarse comparison |
| tbl_we | input | 1 | Write enable for the weight table |
| tbl_addr | input | 8 | Byte value whose weight is written |
| tbl_data | input | 8 | Weight to write |
| out_valid | output | 1 | A result is present |
| out_match | output | 1 | The word looked like valid plaintext |

## Verification
Every verdict is due five rising edges after its word is sampled. The bench keeps a five-slot queue of expected verdicts, pushing one slot per cycle. It compares the oldest slot with the outputs at the falling edge that follows the fifth rising edge, and it checks idle slots for a low `out_valid`. A table write takes effect for the next word: the weight seen by a word on the same edge as the write is the old one. The bench therefore computes each expected sum from its own copy of the table before applying that cycle's write. Reset empties the queue, and the outputs are checked to be low during reset and until the first new word has come out.

// File: rtl/scorer_pkg.sv
package scorer_pkg;
    // default geometry of the scorer
    localparam int WORD_W_DEF      = 64;
    localparam int BYTE_W_DEF      = 8;
    localparam int SCORE_W_DEF     = 8;
    localparam int COARSE_BITS_DEF = 4;
endpackage

// File: rtl/score_bank.sv
// One copy of the weight table with two registered read ports and one write port.
module score_bank #(
    parameter int ADDR_W  = 8,
    parameter int SCORE_W = 8
) (
    input  logic               clk,
    input  logic               we,
    input  logic [ADDR_W-1:0]  waddr,
    input  logic [SCORE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]  ra,
    input  logic [ADDR_W-1:0]  rb,
    output logic [SCORE_W-1:0] qa,
    output logic [SCORE_W-1:0] qb
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [SCORE_W-1:0] mem [DEPTH];
    logic [SCORE_W-1:0] qa_d, qb_d, qa_q, qb_q;

    always_comb begin
        qa_d = mem[ra];
        qb_d = mem[rb];
    end

    // reads return the contents from before a write on the same edge
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        qa_q <= qa_d;
        qb_q <= qb_d;
    end

    assign qa = qa_q;
    assign qb = qb_q;
endmodule

// File: rtl/score_adder_level.sv
// One registered level of the adder tree: adds neighbouring pairs.
module score_adder_level #(
    parameter int N_IN = 8,
    parameter int W_IN = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [N_IN*W_IN-1:0]                in_bus,
    output logic [(N_IN/2)*(W_IN+1)-1:0]        out_bus
);
    localparam int N_OUT = N_IN / 2;
    localparam int W_OUT = W_IN + 1;

    logic [N_OUT*W_OUT-1:0] sum_d, sum_q;

    always_comb begin
        for (int k = 0; k < N_OUT; k++) begin
            sum_d[k*W_OUT +: W_OUT] = W_OUT'(in_bus[(2*k)*W_IN +: W_IN])
                                    + W_OUT'(in_bus[(2*k+1)*W_IN +: W_IN]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign out_bus = sum_q;
endmodule

// File: rtl/plaintext_scorer.sv
module plaintext_scorer #(
    parameter int WORD_W      = scorer_pkg::WORD_W_DEF,
    parameter int BYTE_W      = scorer_pkg::BYTE_W_DEF,
    parameter int SCORE_W     = scorer_pkg::SCORE_W_DEF,
    parameter int COARSE_BITS = scorer_pkg::COARSE_BITS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic [WORD_W-1:0] ref_word,
    input  logic              coarse_en,
    input  logic              tbl_we,
    input  logic [BYTE_W-1:0] tbl_addr,
    input  logic [SCORE_W-1:0] tbl_data,
    output logic              out_valid,
    output logic              out_match
);
    localparam int LANES    = WORD_W / BYTE_W;
    localparam int BANKS    = LANES / 2;
    localparam int LVLS     = $clog2(LANES);
    localparam int SUM_W    = SCORE_W + LVLS;
    localparam int SIDE_STG = LVLS + 1;

    typedef struct packed {
        logic             vld;
        logic             coarse;
        logic [SUM_W-1:0] thr;
    } side_t;

    typedef struct packed {
        side_t [SIDE_STG-1:0] side;
        logic                 out_vld;
        logic                 out_hit;
    } state_t;

    state_t st_d, st_q;

    // ---------------- lookup stage ----------------
    logic [LANES*SCORE_W-1:0] look_scores;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        score_bank #(.ADDR_W(BYTE_W), .SCORE_W(SCORE_W)) u_bank (
            .clk   (clk),
            .we    (tbl_we),
            .waddr (tbl_addr),
            .wdata (tbl_data),
            .ra    (in_word[(2*b)*BYTE_W +: BYTE_W]),
            .rb    (in_word[(2*b+1)*BYTE_W +: BYTE_W]),
            .qa    (look_scores[(2*b)*SCORE_W +: SCORE_W]),
            .qb    (look_scores[(2*b+1)*SCORE_W +: SCORE_W])
        );
    end

    // ---------------- adder tree ----------------
    for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
        logic [(LANES>>l)*(SCORE_W+l)-1:0] bus;
        if (l == 0) begin : g_src
            assign bus = look_scores;
        end else begin : g_add
            score_adder_level #(.N_IN(LANES >> (l-1)), .W_IN(SCORE_W + l - 1)) u_add (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_bus  (g_lvl[l-1].bus),
                .out_bus (bus)
            );
        end
    end

    logic [SUM_W-1:0] total;
    assign total = g_lvl[LVLS].bus;

    logic unused_ref_hi;
    assign unused_ref_hi = ^ref_word[WORD_W-1:SUM_W];

    // ---------------- sideband and compare ----------------
    side_t last;
    logic  above;

    always_comb begin
        st_d = st_q;
        st_d.side[0].vld    = in_valid;
        st_d.side[0].coarse = coarse_en;
        st_d.side[0].thr    = ref_word[SUM_W-1:0];
        for (int i = 1; i < SIDE_STG; i++) begin
            st_d.side[i] = st_q.side[i-1];
        end
        last = st_q.side[SIDE_STG-1];
        if (last.coarse) begin
            above = total[SUM_W-1 -: COARSE_BITS] > last.thr[SUM_W-1 -: COARSE_BITS];
        end else begin
            above = total > last.thr;
        end
        st_d.out_vld = last.vld;
        st_d.out_hit = last.vld & above;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.out_vld;
    assign out_match = st_q.out_hit;
endmodule

// File: rtl/scorer_chk.sv
module scorer_chk #(
    parameter int WORD_W      = scorer_pkg::WORD_W_DEF,
    parameter int BYTE_W      = scorer_pkg::BYTE_W_DEF,
    parameter int SCORE_W     = scorer_pkg::SCORE_W_DEF,
    parameter int COARSE_BITS = scorer_pkg::COARSE_BITS_DEF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              coarse_en,
    input logic [WORD_W-1:0] ref_word,
    input logic              out_valid,
    input logic              out_match
);
    localparam int SUM_W = SCORE_W + $clog2(WORD_W / BYTE_W);
    localparam int LAT   = 5;

    logic [SUM_W-1:0] thr;
    assign thr = ref_word[SUM_W-1:0];
    logic unused_hi;
    assign unused_hi = ^ref_word[WORD_W-1:SUM_W];

    // counts edges since reset so that $past never reaches before it
    logic [2:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q < 3'(LAT)) age_q <= age_q + 3'd1;
    end

    // R7
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_match |-> out_valid);

    // R5
    fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 3'(LAT)) |-> (out_valid == $past(in_valid, 5)));

    // R1
    full_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q == 3'(LAT)) && $past(in_valid, 5) && !$past(coarse_en, 5)
         && ($past(thr, 5) == {SUM_W{1'b1}})) |-> !out_match);

    // R4
    coarse_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q == 3'(LAT)) && $past(coarse_en, 5)
         && ($past(thr[SUM_W-1 -: COARSE_BITS], 5) == {COARSE_BITS{1'b1}})) |-> !out_match);

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_match));
endmodule

bind plaintext_scorer scorer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .coarse_en (coarse_en),
    .ref_word  (ref_word),
    .out_valid (out_valid),
    .out_match (out_match)
);

// File: tb/test_plaintext_scorer.sv
module test_plaintext_scorer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] in_word;
    logic [63:0] ref_word;
    logic        coarse_en;
    logic        tbl_we;
    logic [7:0]  tbl_addr;
    logic [7:0]  tbl_data;
    logic        out_valid;
    logic        out_match;

    plaintext_scorer i_plaintext_scorer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .ref_word(ref_word), .coarse_en(coarse_en), .tbl_we(tbl_we),
        .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .out_valid(out_valid), .out_match(out_match)
    );

    // 125 MHz: 8 time units per period
    always #4 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0] model [256];

    // expected-verdict queue, slot 4 is the oldest
    logic  p_v [5];
    logic  p_m [5];
    int    p_s [5];
    string p_t [5];

    function automatic int sum_of(input logic [63:0] w);
        int s = 0;
        for (int k = 0; k < 8; k++) s += int'(model[w[8*k +: 8]]);
        return s;
    endfunction

    function automatic logic verdict(input int s, input logic [10:0] thr, input logic c);
        logic [10:0] s11 = 11'(s);
        if (c) return s11[10:7] > thr[10:7];
        return s11 > thr;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_pipe();
        for (int i = 0; i < 5; i++) begin
            p_v[i] = 0; p_m[i] = 0; p_s[i] = 0; p_t[i] = "R5";
        end
    endtask

    // called at a falling edge: checks the oldest slot, then drives one cycle
    task automatic step(input logic v, input logic [63:0] w, input logic [63:0] r,
                        input logic c, input string tag,
                        input logic we = 0, input logic [7:0] wa = 0, input logic [7:0] wd = 0);
        if (p_v[4]) begin
            chk(out_valid == 1'b1, {p_t[4], " valid"}, int'(out_valid), 1);
            chk(out_match == p_m[4], {p_t[4], " match"}, int'(out_match), int'(p_m[4]));
        end else begin
            chk(out_valid == 1'b0, "R5 idle valid", int'(out_valid), 0);
            chk(out_match == 1'b0, "R7 idle match", int'(out_match), 0);
        end
        for (int i = 4; i > 0; i--) begin
            p_v[i] = p_v[i-1]; p_m[i] = p_m[i-1]; p_s[i] = p_s[i-1]; p_t[i] = p_t[i-1];
        end
        p_v[0] = v;
        p_s[0] = sum_of(w);
        p_m[0] = v & verdict(p_s[0], r[10:0], c);
        p_t[0] = tag;
        in_valid = v; in_word = w; ref_word = r; coarse_en = c;
        tbl_we = we; tbl_addr = wa; tbl_data = wd;
        if (we) model[wa] = wd;   // same-edge word already used the old weight
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 64'h0, 64'h0, 0, "R5");
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] w, r;
        int          s, d, t;
        string       tg;
        void'($urandom(32'd4242));
        rst_n = 0; in_valid = 0; in_word = '0; ref_word = '0; coarse_en = 0;
        tbl_we = 0; tbl_addr = '0; tbl_data = '0;
        for (int i = 0; i < 256; i++) model[i] = '0;
        clear_pipe();
        repeat (3) @(negedge clk);
        // R9: outputs low during reset
        chk(out_valid == 0, "R9 reset valid", int'(out_valid), 0);
        chk(out_match == 0, "R9 reset match", int'(out_match), 0);
        rst_n = 1;

        // train the table with random weights (R8 write path)
        for (int i = 0; i < 256; i++) step(0, 64'h0, 64'h0, 0, "R8", 1, 8'(i), 8'($urandom()));
        step(0, 64'h0, 64'h0, 0, "R8", 1, 8'hFF, 8'd255);
        step(0, 64'h0, 64'h0, 0, "R8", 1, 8'h11, 8'd10);
        step(0, 64'h0, 64'h0, 0, "R8", 1, 8'h00, 8'd0);

        // R6: random stream with thresholds near the sum
        for (int n = 0; n < 600; n++) begin
            w = rnd64();
            s = sum_of(w);
            d = int'($urandom_range(0, 6)) - 3;
            t = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 2047)) : s + d;
            if (t < 0) t = 0;
            if (t > 2047) t = 2047;
            r = rnd64();
            r[10:0] = 11'(t);
            tg = (t == s) ? "R3" : "R6";
            step($urandom_range(0, 3) != 0, w, r, $urandom_range(0, 3) == 0, tg);
        end

        // R2: maximum sum 2040 with all bytes 0xFF
        step(1, {8{8'hFF}}, 64'd2039, 0, "R2 max sum above 2039");
        step(1, {8{8'hFF}}, 64'd2040, 0, "R3 equal 2040");
        step(1, {8{8'hFF}}, 64'd2047, 0, "R1 ceiling");
        step(1, {8{8'hFF}}, {53'h1F_FFFF_FFFF_FFFF, 11'd100}, 0, "R1 high ref bits");
        step(1, 64'h0, 64'd0, 0, "R3 zero sum zero thr");
        // R4: coarse compares top nibble only
        step(1, {8{8'hFF}}, 64'd1921, 0, "R1 full 2040>1921");
        step(1, {8{8'hFF}}, 64'd1921, 1, "R4 coarse nibble equal");
        step(1, {8{8'hFF}}, 64'd1919, 1, "R4 coarse nibble below");
        step(1, {8{8'hFF}}, 64'd2047, 1, "R4 coarse ceiling");
        idle(6);

        // R8: write on the same edge as a word, then the next word sees it
        step(1, {8{8'h11}}, 64'd100, 0, "R8 old weight", 1, 8'h11, 8'd20);
        step(1, {8{8'h11}}, 64'd100, 0, "R8 new weight");
        idle(6);

        // R9: reset with words in flight, table survives
        for (int n = 0; n < 3; n++) step(1, rnd64(), 64'd0, 0, "R9");
        rst_n = 0;
        clear_pipe();
        repeat (2) begin
            @(negedge clk);
            chk(out_valid == 0, "R9 flush valid", int'(out_valid), 0);
            chk(out_match == 0, "R9 flush match", int'(out_match), 0);
        end
        rst_n = 1;
        in_valid = 0;
        idle(6);
        step(1, {8{8'hFF}}, 64'd2039, 0, "R9 table kept");
        step(1, {8{8'h11}}, 64'd159, 0, "R9 table kept 0x11");
        idle(6);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule